// File: doc/BRIEF.md
# Page Translation Cache with Line and Full Invalidate

This block holds a small set of recent page translations for an address translation unit. Each line pairs a 20-bit virtual page number with a 20-bit physical page number and two access permission flags (read and write). A lookup presents a 32-bit virtual address. When a line holds that page, the block reports a hit in the same cycle. It returns the physical address, built from the stored physical page and the untouched 12-bit page offset, together with the permission flags.

A table walker installs translations through a fill port. The fill carries the virtual address and the raw 32-bit page table entry. Software maintenance reaches the block through two paths. A single-line shootdown takes a virtual address and drops the line for that page. A flush pulse empties every line and sends the replacement pointer back to line 0. New pages go into lines in round-robin order. A fill for a page that is already cached rewrites that line in place.

Top module: `xlate_cache`

## Requirements
- R1: When a valid line's virtual page equals `lk_va[31:12]`, `lk_hit` is 1 in the same cycle and `lk_pa` equals the stored physical page concatenated with `lk_va[11:0]`. On a miss, `lk_hit`, `lk_pa`, `lk_rd` and `lk_wr` are all 0.
- R2: A cycle with `inv_en` high removes the line whose page equals `inv_va[31:12]`. Lines holding other pages keep their contents.
- R3: A cycle with `flush` high invalidates every line and returns the replacement pointer to line 0.
- R4: A fill stores `fill_pte[31:12]` as the physical page, `fill_pte[1]` as the read flag and `fill_pte[2]` as the write flag. A later lookup of the page returns those flags on `lk_rd` and `lk_wr`.
- R5: A lookup reports a miss in any cycle where `flush` is high, or where `inv_en` is high and `inv_va[31:12]` equals `lk_va[31:12]`.
- R6: A fill whose `fill_pte[0]` is 0 changes nothing.
- R7: Fills of pages not already cached are written to lines 0, 1, ..., N-1 in turn and then wrap to line 0, evicting whatever that line held.
- R8: A fill for a page already cached rewrites that line's contents and does not advance the replacement pointer. No two lines ever hold the same page.
- R9: Within one cycle, flush takes priority over a fill. A fill whose page equals the page being invalidated in that cycle is dropped.
- R10: After reset, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_rd | output | 1 | Read permitted |
| lk_wr | output | 1 | Write permitted |
| fill_en | input | 1 | Install a translation |
| fill_va | input | 32 | Virtual address of the fill |
| fill_pte | input | 32 | Page table entry for the fill |
| inv_en | input | 1 | Invalidate one line |
| inv_va | input | 32 | Address whose page is invalidated |
| flush | input | 1 | Invalidate all lines |

## Verification
The bench targets stale hits, which are the main hazard of this block. It checks that a lookup misses in the very cycle an invalidate or flush names its page. A design that let the old line answer during that cycle would return a translation that is already being withdrawn. It also fills every line and then fills one more. Only the oldest page should disappear, so a wrong victim pointer shows up as the wrong page missing.

A refill of a cached page is followed by a fresh fill. If the refill had made a duplicate line, or had advanced the pointer, the wrong page would be evicted. Fills with the valid bit clear, and fills that collide with a same-cycle invalidate, must leave no line behind. A design that let either through would keep hitting on that page.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int PAGE_W = VA_W - OFF_W;

  // Bit positions inside a page table entry used by the fill path.
  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_RD_BIT    = 1;
  localparam int PTE_WR_BIT    = 2;

  typedef struct packed {
    logic [PAGE_W-1:0] ppn;
    logic              rd;
    logic              wr;
  } xlc_data_t;
endpackage

// File: rtl/xlc_rr.sv
module xlc_rr #(
  parameter int NENT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            restart,
  output logic [NENT-1:0] victim
);
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NENT - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = restart | advance;
    if (restart)           ptr_d = '0;
    else if (ptr_q == LAST) ptr_d = '0;
    else                   ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_comb begin
    victim = '0;
    victim[ptr_q] = 1'b1;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && ptr_q == LAST) |=> (ptr_q == '0)); // R7
endmodule

// File: rtl/xlc_line.sv
module xlc_line
  import xlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] lk_tag,
  input  logic [PAGE_W-1:0] wr_tag,
  input  logic              wr_en,
  input  xlc_data_t         wr_data,
  input  logic              inv_en,
  input  logic [PAGE_W-1:0] inv_tag,
  input  logic              flush,
  output logic              valid,
  output logic              lk_match,
  output logic              wr_match,
  output xlc_data_t         data
);
  logic              valid_q, valid_d;
  logic [PAGE_W-1:0] tag_q;
  xlc_data_t         data_q;
  logic              inv_hit;

  assign inv_hit = inv_en && valid_q && (tag_q == inv_tag);

  always_comb begin
    valid_d = valid_q;
    if (flush)        valid_d = 1'b0;
    else if (wr_en)   valid_d = 1'b1;
    else if (inv_hit) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q  <= wr_tag;
      data_q <= wr_data;
    end
  end

  assign valid    = valid_q;
  assign lk_match = valid_q && (tag_q == lk_tag);
  assign wr_match = valid_q && (tag_q == wr_tag);
  assign data     = data_q;

  AST_LINE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit && !flush && !wr_en) |=> !valid_q); // R2
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int NENT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lk_va,
  output logic        lk_hit,
  output logic [31:0] lk_pa,
  output logic        lk_rd,
  output logic        lk_wr,
  input  logic        fill_en,
  input  logic [31:0] fill_va,
  input  logic [31:0] fill_pte,
  input  logic        inv_en,
  input  logic [31:0] inv_va,
  input  logic        flush
);
  logic [PAGE_W-1:0] lk_tag, fill_tag, inv_tag;
  logic [NENT-1:0]   valid_vec, lk_match, wr_match, victim, wr_sel, wr_vec;
  xlc_data_t         line_data [NENT];
  xlc_data_t         fill_data, hit_data;
  logic              fill_ok, fill_present, lk_block;

  assign lk_tag   = lk_va[VA_W-1:OFF_W];
  assign fill_tag = fill_va[VA_W-1:OFF_W];
  assign inv_tag  = inv_va[VA_W-1:OFF_W];

  assign fill_data.ppn = fill_pte[VA_W-1:OFF_W];
  assign fill_data.rd  = fill_pte[PTE_RD_BIT];
  assign fill_data.wr  = fill_pte[PTE_WR_BIT];

  // Fill qualification: valid entry, no flush, no collision with shootdown.
  always_comb begin
    fill_ok      = fill_en && fill_pte[PTE_VALID_BIT] && !flush &&
                   !(inv_en && (inv_tag == fill_tag));
    fill_present = |wr_match;
    wr_sel       = fill_present ? wr_match : victim;
    wr_vec       = fill_ok ? wr_sel : '0;
  end

  xlc_rr #(.NENT(NENT)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (fill_ok && !fill_present),
    .restart (flush),
    .victim  (victim)
  );

  for (genvar i = 0; i < NENT; i++) begin : g_line
    xlc_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_tag   (lk_tag),
      .wr_tag   (fill_tag),
      .wr_en    (wr_vec[i]),
      .wr_data  (fill_data),
      .inv_en   (inv_en),
      .inv_tag  (inv_tag),
      .flush    (flush),
      .valid    (valid_vec[i]),
      .lk_match (lk_match[i]),
      .wr_match (wr_match[i]),
      .data     (line_data[i])
    );
  end

  // Lookup: masked in the cycle its page is being withdrawn.
  always_comb begin
    lk_block = flush || (inv_en && (inv_tag == lk_tag));
    hit_data = '0;
    for (int i = 0; i < NENT; i++) begin
      if (lk_match[i]) hit_data = hit_data | line_data[i];
    end
    lk_hit = (|lk_match) && !lk_block;
    lk_pa  = lk_hit ? {hit_data.ppn, lk_va[OFF_W-1:0]} : '0;
    lk_rd  = lk_hit && hit_data.rd;
    lk_wr  = lk_hit && hit_data.wr;
  end

  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R3
  AST_SAME_CYCLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || (inv_en && inv_va[31:12] == lk_va[31:12])) |-> !lk_hit); // R5
  AST_BAD_PTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_pte[0] && !inv_en && !flush) |=> $stable(valid_vec)); // R6
  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && fill_en && inv_va[31:12] == fill_va[31:12]) |=> !(|wr_match)); // R9
endmodule

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  localparam int N = 8;

  logic        clk, rst_n;
  logic [31:0] lk_va, lk_pa, fill_va, fill_pte, inv_va;
  logic        lk_hit, lk_rd, lk_wr, fill_en, inv_en, flush;
  int          total, bad;

  xlate_cache #(.NENT(N)) uut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .lk_rd(lk_rd), .lk_wr(lk_wr), .fill_en(fill_en), .fill_va(fill_va),
    .fill_pte(fill_pte), .inv_en(inv_en), .inv_va(inv_va), .flush(flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic expect_lk(input [31:0] va, input bit hit, input [31:0] pa,
                           input bit rd, input bit wr, input string req);
    lk_va = va;
    #1;
    total++;
    if (lk_hit !== hit || lk_pa !== pa || lk_rd !== rd || lk_wr !== wr) begin
      bad++;
      $display("FAIL %s va=%h: got hit=%b pa=%h rd=%b wr=%b exp hit=%b pa=%h rd=%b wr=%b",
               req, va, lk_hit, lk_pa, lk_rd, lk_wr, hit, pa, rd, wr);
    end
  endtask

  task automatic do_fill(input [31:0] va, input [31:0] pte);
    @(negedge clk);
    fill_en = 1'b1; fill_va = va; fill_pte = pte;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_inv(input [31:0] va);
    @(negedge clk);
    inv_en = 1'b1; inv_va = va;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_lk(32'h0000_0000, 0, 0, 0, 0, "R10");
    expect_lk(32'h1234_5678, 0, 0, 0, 0, "R10");
  endtask

  task automatic t_fill();
    do_fill(32'h1234_5000, 32'hABCD_E007);
    do_fill(32'h2000_0000, 32'h0001_1003);
    do_fill(32'h3000_0000, 32'h0002_2005);
    expect_lk(32'h1234_5ABC, 1, 32'hABCD_EABC, 1, 1, "R1");
    expect_lk(32'h2000_0FFF, 1, 32'h0001_1FFF, 1, 0, "R4");
    expect_lk(32'h3000_0001, 1, 32'h0002_2001, 0, 1, "R4");
    expect_lk(32'h1234_6000, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_bad_pte();
    do_fill(32'h4000_0000, 32'h0003_3006);
    expect_lk(32'h4000_0000, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_inval();
    do_inv(32'h2000_0ABC);
    expect_lk(32'h2000_0000, 0, 0, 0, 0, "R2");
    expect_lk(32'h1234_5000, 1, 32'hABCD_E000, 1, 1, "R2");
    expect_lk(32'h3000_0000, 1, 32'h0002_2000, 0, 1, "R2");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    inv_en = 1'b1; inv_va = 32'h1234_5FFF;
    expect_lk(32'h1234_5010, 0, 0, 0, 0, "R5");
    expect_lk(32'h3000_0000, 1, 32'h0002_2000, 0, 1, "R5");
    @(negedge clk);
    inv_en = 1'b0;
    expect_lk(32'h1234_5010, 0, 0, 0, 0, "R2");
    flush = 1'b1;
    expect_lk(32'h3000_0000, 0, 0, 0, 0, "R5");
    @(negedge clk);
    flush = 1'b0;
    expect_lk(32'h3000_0000, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_round_robin();
    do_flush();
    for (int i = 0; i < N; i++) do_fill(32'h0100_0000 + (i << 12), 32'h0050_0003 + (i << 12));
    expect_lk(32'h0100_0000, 1, 32'h0050_0000, 1, 0, "R7");
    do_fill(32'h0200_0000, 32'h0060_0005);
    expect_lk(32'h0100_0000, 0, 0, 0, 0, "R7");
    expect_lk(32'h0100_1000, 1, 32'h0050_1000, 1, 0, "R7");
    expect_lk(32'h0200_0000, 1, 32'h0060_0000, 0, 1, "R7");
  endtask

  task automatic t_refill();
    do_flush();
    for (int i = 0; i < N; i++) do_fill(32'h0300_0000 + (i << 12), 32'h0070_0003 + (i << 12));
    do_fill(32'h0300_0000, 32'h0080_0005);
    expect_lk(32'h0300_0123, 1, 32'h0080_0123, 0, 1, "R8");
    do_fill(32'h0400_0000, 32'h0090_0007);
    expect_lk(32'h0300_0000, 0, 0, 0, 0, "R8");
    expect_lk(32'h0300_1000, 1, 32'h0070_1000, 1, 0, "R8");
  endtask

  task automatic t_priority();
    @(negedge clk);
    fill_en = 1'b1; fill_va = 32'h0500_0000; fill_pte = 32'h00A0_0003;
    inv_en = 1'b1; inv_va = 32'h0500_0000;
    @(negedge clk);
    fill_en = 1'b0; inv_en = 1'b0;
    expect_lk(32'h0500_0000, 0, 0, 0, 0, "R9");
    @(negedge clk);
    fill_en = 1'b1; fill_va = 32'h0600_0000; fill_pte = 32'h00B0_0003;
    flush = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
    expect_lk(32'h0600_0000, 0, 0, 0, 0, "R9");
    expect_lk(32'h0400_0000, 0, 0, 0, 0, "R3");
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; lk_va = '0; fill_en = 1'b0; fill_va = '0; fill_pte = '0;
    inv_en = 1'b0; inv_va = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_bad_pte();
    t_inval();
    t_same_cycle();
    t_round_robin();
    t_refill();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule